// File: doc/BRIEF.md
# Banked Coefficient Memory Byte Loader

This block fills the coefficient store of a twelve-tap filter through a narrow byte port and serves the stored coefficient sets back to the multipliers. The store is split into six banks of 108 words. Each 24-bit word carries two 12-bit tap coefficients. Because the byte port is only eight bits wide, the loader keeps two holding bytes. A write aimed at a bank then combines the incoming byte with both holding bytes into one full word and stores it.

The three upper address bits pick the destination: one of the two holding bytes, or one of the six banks. The seven lower bits pick the location inside a bank. The block is in load mode only while the active-low write strobe and the active-low device select are both asserted. At any other time it is in run mode. In run mode the lower address bits choose one of the 108 coefficient sets, and all twelve coefficients appear on the output after one clock edge. A bank write aimed at a location past the end of a bank is discarded and reported with a one-cycle error pulse.

Top module: `coef_bank_loader`

## Requirements
- R1: `load_active` is 1 exactly while `wr_n` and `sel_n` are both 0. A byte is accepted on each rising edge in that state, and on no edge where either of the two is 1.
- R2: A load-mode write with `addr[9:7]` = 3'b110 stores `din` as holding byte low (word bits 7..0). Code 3'b111 stores it as holding byte high (word bits 15..8). For both codes `addr[6:0]` is ignored.
- R3: A load-mode write with `addr[9:7]` = k, where k is 0..5, stores the word {`din`, holding high, holding low} into bank k at location `addr[6:0]`. The holding bytes keep their values after the commit and are reused by later commits.
- R4: Bits 23..12 of a bank k word drive tap 2k+1 on `coef_out[(2k)*12 +: 12]`. Bits 11..0 drive tap 2k+2 on `coef_out[(2k+1)*12 +: 12]`. Taps are numbered 1 to 12.
- R5: On a run-mode rising edge with `addr[6:0]` < 108, all twelve coefficients of that location are registered onto `coef_out`. They are visible after that one edge.
- R6: A load-mode bank write (codes 0..5) with `addr[6:0]` >= 108 writes nothing. It drives `range_err` to 1 for the single cycle after that edge. Holding-byte writes never raise `range_err`, whatever their location bits.
- R7: `coef_out` does not change on an edge taken in load mode. It also does not change on a run-mode edge with `addr[6:0]` >= 108.
- R8: Reset (`rst_n` = 0, asynchronous) clears both holding bytes and `range_err`. It leaves the bank contents as they were. After power-up the bank contents are undefined.
- R9: A run-mode read of a location on the edge right after a commit to that location returns the newly committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| sel_n | input | 1 | Active-low device select |
| din | input | 8 | Data byte |
| addr | input | 10 | Destination code [9:7] and location [6:0] |
| coef_out | output | 144 | Twelve registered 12-bit tap coefficients, tap 1 in the low slice |
| load_active | output | 1 | High while the block is in load mode |
| range_err | output | 1 | One-cycle pulse after a dropped out-of-range bank write |

## Verification
The memory commit and the registered run-mode read can act on the same location in back-to-back edges. If the read path took its data from a stale copy, it would return the old word. The bench provokes this by ending the load phase right after a third-byte commit, with the address still pointing at the location just written. It then compares both affected taps against the word assembled from the bytes it sent. A second pairing is the out-of-range commit against holding-byte writes that carry the same illegal location bits. Here the error pulse must fire for the commit and stay low for the holding-byte writes.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] CODE_HOLD_LO = 3'b110;
  localparam logic [SEL_W-1:0] CODE_HOLD_HI = 3'b111;

  typedef struct packed {
    logic load;
    logic hold_lo_we;
    logic hold_hi_we;
    logic loc_ok;
    logic bad_commit;
  } dec_t;
endpackage

// File: rtl/coef_addr_decode.sv
module coef_addr_decode
  import coef_loader_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int DEPTH     = 108,
  parameter int LOC_W     = 7
) (
  input  logic                   wr_n,
  input  logic                   sel_n,
  input  logic [SEL_W+LOC_W-1:0] addr,
  output dec_t                   dec,
  output logic [NUM_BANKS-1:0]   bank_we
);
  logic [SEL_W-1:0] code;
  logic [LOC_W-1:0] loc;
  logic             bank_hit;

  always_comb begin
    code           = addr[SEL_W+LOC_W-1:LOC_W];
    loc            = addr[LOC_W-1:0];
    bank_hit       = code < SEL_W'(NUM_BANKS);
    dec.load       = ~wr_n & ~sel_n;
    dec.loc_ok     = loc < LOC_W'(DEPTH);
    dec.hold_lo_we = dec.load & (code == CODE_HOLD_LO);
    dec.hold_hi_we = dec.load & (code == CODE_HOLD_HI);
    dec.bad_commit = dec.load & bank_hit & ~dec.loc_ok;
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_we
    assign bank_we[k] = dec.load & dec.loc_ok & (code == SEL_W'(k));
  end
endmodule

// File: rtl/coef_hold_regs.sv
module coef_hold_regs #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] hold_lo,
  output logic [BYTE_W-1:0] hold_hi
);
  logic [BYTE_W-1:0] lo_d, hi_d;

  always_comb begin
    lo_d = hold_lo;
    hi_d = hold_hi;
    if (lo_we) lo_d = din;
    if (hi_we) hi_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_lo <= '0;
      hold_hi <= '0;
    end else begin
      hold_lo <= lo_d;
      hold_hi <= hi_d;
    end
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int WORD_W = 24,
  parameter int DEPTH  = 108,
  parameter int LOC_W  = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic              rd_en,
  input  logic [LOC_W-1:0]  loc,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[loc] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[loc];
  end
endmodule

// File: rtl/coef_bank_loader.sv
module coef_bank_loader
  import coef_loader_pkg::*;
#(
  parameter int NUM_BANKS = 6,
  parameter int DEPTH     = 108,
  parameter int COEF_W    = 12,
  localparam int WORD_W   = 2 * COEF_W,
  localparam int BYTE_W   = WORD_W / 3,
  localparam int LOC_W    = $clog2(DEPTH),
  localparam int ADDR_W   = SEL_W + LOC_W,
  localparam int NUM_TAPS = 2 * NUM_BANKS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_n,
  input  logic                       sel_n,
  input  logic [BYTE_W-1:0]          din,
  input  logic [ADDR_W-1:0]          addr,
  output logic [NUM_TAPS*COEF_W-1:0] coef_out,
  output logic                       load_active,
  output logic                       range_err
);
  dec_t               dec;
  logic [NUM_BANKS-1:0] bank_we;
  logic [BYTE_W-1:0]  hold_lo, hold_hi;
  logic [WORD_W-1:0]  commit_word;
  logic               rd_en;
  logic               err_d;

  coef_addr_decode #(
    .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .LOC_W(LOC_W)
  ) u_dec (
    .wr_n(wr_n), .sel_n(sel_n), .addr(addr), .dec(dec), .bank_we(bank_we)
  );

  coef_hold_regs #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .lo_we(dec.hold_lo_we), .hi_we(dec.hold_hi_we),
    .din(din), .hold_lo(hold_lo), .hold_hi(hold_hi)
  );

  always_comb begin
    commit_word = {din, hold_hi, hold_lo};
    rd_en       = ~dec.load & dec.loc_ok;
    err_d       = dec.bad_commit;
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic [WORD_W-1:0] word_q;
    coef_bank #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LOC_W(LOC_W)) u_bank (
      .clk(clk), .we(bank_we[k]), .rd_en(rd_en), .loc(addr[LOC_W-1:0]),
      .wr_word(commit_word), .rd_word(word_q)
    );
    assign coef_out[(2*k)*COEF_W +: COEF_W]   = word_q[WORD_W-1 -: COEF_W];
    assign coef_out[(2*k+1)*COEF_W +: COEF_W] = word_q[COEF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) range_err <= 1'b0;
    else        range_err <= err_d;
  end

  assign load_active = dec.load;
endmodule

// File: rtl/coef_bank_loader_chk.sv
module coef_bank_loader_chk #(
  parameter int NUM_BANKS = 6,
  parameter int DEPTH     = 108,
  parameter int LOC_W     = 7,
  parameter int BYTE_W    = 8,
  parameter int OUT_W     = 144
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_n,
  input logic                 sel_n,
  input logic [BYTE_W-1:0]    din,
  input logic [LOC_W+2:0]     addr,
  input logic [OUT_W-1:0]     coef_out,
  input logic                 load_active,
  input logic                 range_err,
  input logic [NUM_BANKS-1:0] bank_we,
  input logic [BYTE_W-1:0]    hold_lo
);
  logic illegal_commit;
  assign illegal_commit = !wr_n && !sel_n && (addr[LOC_W+2:LOC_W] < 3'(NUM_BANKS))
                          && (addr[LOC_W-1:0] >= LOC_W'(DEPTH));

  // R1
  bank_we_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we != '0) |-> (!wr_n && !sel_n && $onehot0(bank_we)));

  // R2
  hold_lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!wr_n && !sel_n && addr[LOC_W+2:LOC_W] == 3'b110))
    |-> (hold_lo == $past(din)));

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> $past(illegal_commit));

  // R6
  err_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(illegal_commit)) |-> range_err);

  // R7
  hold_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_active)) |-> $stable(coef_out));
endmodule

bind coef_bank_loader coef_bank_loader_chk #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .LOC_W(LOC_W), .BYTE_W(BYTE_W),
  .OUT_W(NUM_TAPS*COEF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_n(sel_n), .din(din), .addr(addr),
  .coef_out(coef_out), .load_active(load_active), .range_err(range_err),
  .bank_we(bank_we), .hold_lo(hold_lo)
);

// File: tb/tb_coef_bank_loader.sv
module tb_coef_bank_loader;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_n, sel_n;
  logic [7:0]   din;
  logic [9:0]   addr;
  logic [143:0] coef_out;
  logic         load_active, range_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  coef_bank_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_n(sel_n), .din(din),
    .addr(addr), .coef_out(coef_out), .load_active(load_active),
    .range_err(range_err)
  );

  typedef struct packed {
    logic       rd;
    logic [9:0] a;
    logic [7:0] d;
    logic [3:0] tap;
    logic [11:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h300, 8'hF4, 4'd0,  12'h000},
    '{1'b0, 10'h380, 8'h2E, 4'd0,  12'h000},
    '{1'b0, 10'h000, 8'hFB, 4'd0,  12'h000},
    '{1'b1, 10'h000, 8'h00, 4'd1,  12'hFB2},
    '{1'b1, 10'h000, 8'h00, 4'd2,  12'hEF4},
    '{1'b0, 10'h36B, 8'hCD, 4'd0,  12'h000},
    '{1'b0, 10'h3EB, 8'hDD, 4'd0,  12'h000},
    '{1'b0, 10'h2EB, 8'hCC, 4'd0,  12'h000},
    '{1'b1, 10'h06B, 8'h00, 4'd11, 12'hCCD},
    '{1'b1, 10'h06B, 8'h00, 4'd12, 12'hDCD},
    '{1'b1, 10'h000, 8'h00, 4'd1,  12'hFB2},
    '{1'b0, 10'h300, 8'h11, 4'd0,  12'h000},
    '{1'b0, 10'h380, 8'h22, 4'd0,  12'h000},
    '{1'b0, 10'h085, 8'h33, 4'd0,  12'h000},
    '{1'b1, 10'h005, 8'h00, 4'd3,  12'h332},
    '{1'b1, 10'h005, 8'h00, 4'd4,  12'h211},
    '{1'b0, 10'h105, 8'h44, 4'd0,  12'h000},
    '{1'b1, 10'h005, 8'h00, 4'd5,  12'h442},
    '{1'b1, 10'h005, 8'h00, 4'd6,  12'h211},
    '{1'b1, 10'h005, 8'h00, 4'd3,  12'h332},
    '{1'b1, 10'h000, 8'h00, 4'd2,  12'hEF4}
  };

  function automatic logic [11:0] tap_of(input int t);
    return coef_out[(t-1)*12 +: 12];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // each op starts at a falling edge and ends at the next falling edge
  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    wr_n = 1'b0; sel_n = 1'b0; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [9:0] a);
    wr_n = 1'b1; sel_n = 1'b1; addr = a; din = 8'h00;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; sel_n = 1'b1; din = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 range_err after reset", 32'(range_err), 32'd0);
    check("R1 load_active idle", 32'(load_active), 32'd0);

    // vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        rd(VECS[i].a);
        check("R3/R4/R5 table read", 32'(tap_of(int'(VECS[i].tap))), 32'(VECS[i].exp));
      end else begin
        wr(VECS[i].a, VECS[i].d);
      end
    end

    // R1: only one of the two strobes low does nothing
    wr_n = 1'b0; sel_n = 1'b1; addr = 10'h000; din = 8'h77;
    #1 check("R1 strobe only", 32'(load_active), 32'd0);
    @(negedge clk);
    wr_n = 1'b1; sel_n = 1'b0;
    #1 check("R1 select only", 32'(load_active), 32'd0);
    @(negedge clk);
    wr_n = 1'b0; sel_n = 1'b0; addr = 10'h300; din = 8'h55;
    #1 check("R1 both low", 32'(load_active), 32'd1);
    @(negedge clk);
    rd(10'h000);
    check("R1 ignored write left tap1", 32'(tap_of(1)), 32'hFB2);

    // R7: output holds in load mode and on illegal run location
    rd(10'h005);
    check("R7 setup tap3", 32'(tap_of(3)), 32'h332);
    wr(10'h300, 8'h55);
    check("R7 hold during load", 32'(tap_of(3)), 32'h332);
    rd(10'h07F);
    check("R7 hold on illegal location", 32'(tap_of(3)), 32'h332);

    // R6: out-of-range commit dropped and flagged
    wr(10'h06C, 8'hEE);
    check("R6 error pulse", 32'(range_err), 32'd1);
    rd(10'h000);
    check("R6 pulse single cycle", 32'(range_err), 32'd0);
    check("R6 bank untouched", 32'(tap_of(1)), 32'hFB2);
    wr(10'h36C, 8'h11);
    check("R6 holding low no error", 32'(range_err), 32'd0);
    wr(10'h3EC, 8'h22);
    check("R6 holding high no error", 32'(range_err), 32'd0);

    // R9: read right after commit to same location
    wr(10'h001, 8'h99);
    rd(10'h001);
    check("R9 fresh tap1", 32'(tap_of(1)), 32'h992);
    check("R9 fresh tap2", 32'(tap_of(2)), 32'h211);

    // R8: reset clears holding bytes and error, keeps memory
    wr(10'h07F, 8'h01);
    check("R8 error before reset", 32'(range_err), 32'd1);
    rst_n = 1'b0; wr_n = 1'b1; sel_n = 1'b1;
    #1 check("R8 async clear of error", 32'(range_err), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(10'h180, 8'h5A);
    rd(10'h000);
    check("R8 cleared holding tap7", 32'(tap_of(7)), 32'h5A0);
    check("R8 cleared holding tap8", 32'(tap_of(8)), 32'h000);
    check("R8 memory kept tap1", 32'(tap_of(1)), 32'hFB2);

    finish_run();
  end
endmodule